// File: doc/BRIEF.md
# Pad pull resistor control

This block holds the pull-up and pull-down resistor enables for a port of I/O lines and drives them to the pad ring. Software changes a line's resistors by writing a one to its bit in a set-style or clear-style register. Lines written as zero keep their state. Separate registers turn the pull-up on, turn the pull-up off, turn the pull-down on and turn the pull-down off. Two readable status words report the state of each resistor type.

Status is active-low: a status bit reads 1 when its resistor is off. A request to turn on a resistor is dropped, line by line, when the opposite resistor on that line is on at the moment of the write. Because of this, a line never has both resistors on. The pull-up control works the same way whether the line is used as plain I/O or by a peripheral. After reset every pull-up is on and every pull-down is off.

The bus is a single-cycle synchronous port. It has one address, a write strobe, write data and combinational read data. A write takes effect at the clock edge where the write strobe is sampled high.

Top module: `pull_ctrl`

## Requirements
- R1: After reset, pull-up status reads 0x00000000, pull-down status reads 0xFFFFFFFF, `pu_en_o` is all ones and `pd_en_o` is all zeros.
- R2: A write to address 1 (pull-up off) sets the pull-up status bit of every line whose data bit is 1. Lines written as 0 are unchanged.
- R3: A write to address 0 (pull-up on) clears the pull-up status bit of every line whose data bit is 1, unless R6 blocks it. Lines written as 0 are unchanged.
- R4: Addresses 2 (pull-down on) and 3 (pull-down off) act on the pull-down status in the same way. A write to any of addresses 0 to 3 leaves the other resistor type unchanged.
- R5: A pull-down-on request is ignored for each line whose pull-up was on before the write. Other lines in the same write are still applied.
- R6: A pull-up-on request is ignored for each line whose pull-down was on before the write. Other lines in the same write are still applied.
- R7: No line ever has `pu_en_o` and `pd_en_o` both at 1.
- R8: Reading address 4 returns the pull-up status, which equals `~pu_en_o`. Reading address 5 returns the pull-down status, which equals `~pd_en_o`.
- R9: Reads of addresses 0, 1, 2, 3, 6 and 7 return 0. Writes to addresses 4 to 7 change no state.
- R10: The resistor state changes only at a clock edge where `we_i` is 1. When `we_i` is 0, the address and data have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data, one bit per line |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pu_en_o | output | 32 | Pull-up enable per line, to pads |
| pd_en_o | output | 32 | Pull-down enable per line, to pads |

## Verification
The bench targets partly blocked enable writes. In these writes some lines of one word are refused because the opposite resistor is on, while the rest are applied. A design that tested the conflict against the new state, or blocked the whole word, would show wrong bits on the pad outputs. Writes to the status and unused addresses, and address changes while `we_i` is low, are applied to confirm that no state moves. A decoder that aliased these addresses would corrupt a resistor word. Write-only addresses are read back to confirm they return zero rather than a status word. A random mix of all addresses, checked against a bench model, looks for any cycle where both resistors of a line are on.

// File: rtl/pull_ctrl_pkg.sv
package pull_ctrl_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned NUM_KIND = 2;
  localparam int unsigned KIND_PU  = 0;
  localparam int unsigned KIND_PD  = 1;

  localparam logic [ADDR_W-1:0] ADDR_PU_SET  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PU_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PD_SET  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PD_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PU_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PD_STAT = 3'd5;
endpackage

// File: rtl/pull_ctrl_decode.sv
module pull_ctrl_decode
  import pull_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output logic [NUM_KIND-1:0] set_o,
  output logic [NUM_KIND-1:0] clr_o
);
  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (we_i) begin
      unique case (addr_i)
        ADDR_PU_SET: set_o[KIND_PU] = 1'b1;
        ADDR_PU_CLR: clr_o[KIND_PU] = 1'b1;
        ADDR_PD_SET: set_o[KIND_PD] = 1'b1;
        ADDR_PD_CLR: clr_o[KIND_PD] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pull_ctrl_bank.sv
module pull_ctrl_bank #(
  parameter int unsigned      WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_OFF = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] block_i,  // opposite resistor currently on
  output logic [WIDTH-1:0] off_o
);
  logic [WIDTH-1:0] off_q, off_d, set_m, clr_m;

  always_comb begin
    set_m = set_i ? (data_i & ~block_i) : '0;
    clr_m = clr_i ? data_i : '0;
    off_d = (off_q & ~set_m) | clr_m;  // disable wins on overlap
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= RESET_OFF;
    else         off_q <= off_d;
  end

  assign off_o = off_q;
endmodule

// File: rtl/pull_ctrl_rdmux.sv
module pull_ctrl_rdmux
  import pull_ctrl_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  pu_off_i,
  input  logic [WIDTH-1:0]  pd_off_i,
  output logic [WIDTH-1:0]  rdata_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_PU_STAT: rdata_o = pu_off_i;
      ADDR_PD_STAT: rdata_o = pd_off_i;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pull_ctrl.sv
module pull_ctrl
  import pull_ctrl_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  pu_en_o,
  output logic [WIDTH-1:0]  pd_en_o
);
  logic [NUM_KIND-1:0]            set_stb, clr_stb;
  logic [NUM_KIND-1:0][WIDTH-1:0] off_vec;

  pull_ctrl_decode u_decode (
    .addr_i (addr_i),
    .we_i   (we_i),
    .set_o  (set_stb),
    .clr_o  (clr_stb)
  );

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_bank
    localparam logic [WIDTH-1:0] RST_OFF = (k == KIND_PU) ? {WIDTH{1'b0}} : {WIDTH{1'b1}};
    pull_ctrl_bank #(
      .WIDTH     (WIDTH),
      .RESET_OFF (RST_OFF)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_stb[k]),
      .clr_i   (clr_stb[k]),
      .data_i  (wdata_i),
      .block_i (~off_vec[NUM_KIND-1-k]),
      .off_o   (off_vec[k])
    );
  end

  pull_ctrl_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .addr_i   (addr_i),
    .pu_off_i (off_vec[KIND_PU]),
    .pd_off_i (off_vec[KIND_PD]),
    .rdata_o  (rdata_o)
  );

  assign pu_en_o = ~off_vec[KIND_PU];
  assign pd_en_o = ~off_vec[KIND_PD];
endmodule

// File: rtl/pull_ctrl_chk.sv
module pull_ctrl_chk
  import pull_ctrl_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pu_en_o,
  input logic [WIDTH-1:0]  pd_en_o
);
  p_never_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_en_o & pd_en_o) == '0);

  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pu_en_o) && $stable(pd_en_o)));

  p_pd_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_PD_SET) |=> (pd_en_o & $past(pu_en_o)) == '0);

  p_pu_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_PU_SET) |=> (pu_en_o & $past(pd_en_o)) == '0);

  p_pu_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_PU_CLR) |=> (pu_en_o & $past(wdata_i)) == '0);

  p_status_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_PU_STAT) |-> rdata_o == ~pu_en_o);

  p_wo_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_PU_STAT && addr_i != ADDR_PD_STAT) |-> rdata_o == '0);

  p_status_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[2]) |=> ($stable(pu_en_o) && $stable(pd_en_o)));
endmodule

bind pull_ctrl pull_ctrl_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/pull_ctrl_test.sv
`timescale 1ns/1ps
module pull_ctrl_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, pu_en, pd_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state, active-low status
  logic [W-1:0] m_pu_off, m_pd_off;

  always #2.5 clk = ~clk;

  pull_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pu_en_o(pu_en), .pd_en_o(pd_en)
  );

  function automatic logic [W-1:0] next_pu(logic [2:0] a, logic [W-1:0] d,
                                           logic [W-1:0] pu, logic [W-1:0] pd);
    if (a == 3'd0) return pu & ~(d & pd);
    if (a == 3'd1) return pu | d;
    return pu;
  endfunction

  function automatic logic [W-1:0] next_pd(logic [2:0] a, logic [W-1:0] d,
                                           logic [W-1:0] pu, logic [W-1:0] pd);
    if (a == 3'd2) return pd & ~(d & pu);
    if (a == 3'd3) return pd | d;
    return pd;
  endfunction

  function automatic logic [W-1:0] exp_read(logic [2:0] a);
    if (a == 3'd4) return m_pu_off;
    if (a == 3'd5) return m_pd_off;
    return '0;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pads(string tag);
    check({tag, " pu_en"}, pu_en, ~m_pu_off);
    check({tag, " pd_en"}, pd_en, ~m_pd_off);
  endtask

  // drive at negedge, commit at posedge, back at next negedge
  task automatic bus_write(logic [2:0] a, logic [W-1:0] d, logic en);
    addr = a; wdata = d; we = en;
    @(posedge clk);
    if (en) begin
      logic [W-1:0] npu, npd;
      npu = next_pu(a, d, m_pu_off, m_pd_off);
      npd = next_pd(a, d, m_pu_off, m_pd_off);
      m_pu_off = npu;
      m_pd_off = npd;
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(string tag, logic [2:0] a);
    addr = a; we = 1'b0;
    #1;
    check(tag, rdata, exp_read(a));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_pu_off = '0;
    m_pd_off = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R8 status reads
    check("R1 pu_en reset", pu_en, 32'hFFFF_FFFF);
    check("R1 pd_en reset", pd_en, 32'h0000_0000);
    bus_read("R1 R8 pu status reset", 3'd4);
    bus_read("R1 R8 pd status reset", 3'd5);

    // R5 fully blocked pull-down enable
    bus_write(3'd2, 32'hFFFF_FFFF, 1'b1);
    check("R5 pd fully blocked", pd_en, 32'h0000_0000);

    // R2 pull-up off on low half
    bus_write(3'd1, 32'h0000_FFFF, 1'b1);
    check("R2 pu_off half", pu_en, 32'hFFFF_0000);

    // R5 partial block, R4 pd on
    bus_write(3'd2, 32'hFFFF_FFFF, 1'b1);
    check("R5 pd partial", pd_en, 32'h0000_FFFF);
    check("R4 pu untouched", pu_en, 32'hFFFF_0000);

    // R6 fully blocked on low half
    bus_write(3'd0, 32'h0000_FFFF, 1'b1);
    check("R6 pu blocked", pu_en, 32'hFFFF_0000);

    // R4 pd off on a byte
    bus_write(3'd3, 32'h0000_00FF, 1'b1);
    check("R4 pd_off byte", pd_en, 32'h0000_FF00);

    // R3 and R6: line 8 blocked, lines 0..7 applied
    bus_write(3'd0, 32'h0000_01FF, 1'b1);
    check("R3 R6 pu mixed", pu_en, 32'hFFFF_00FF);
    check("R7 no overlap", pu_en & pd_en, '0);

    // R9 writes to status and unused addresses
    for (int a = 4; a < 8; a++) begin
      bus_write(3'(a), 32'hFFFF_FFFF, 1'b1);
      check_pads("R9 status/unused write");
    end
    bus_write(3'd0, 32'h0000_0000, 1'b1);
    check_pads("R3 zero-data write");

    // R10 strobe low
    bus_write(3'd1, 32'hFFFF_FFFF, 1'b0);
    bus_write(3'd2, 32'hFFFF_FFFF, 1'b0);
    check_pads("R10 no strobe");

    // R9 write-only reads
    for (int a = 0; a < 8; a++) bus_read("R9 R8 read", 3'(a));

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]   a;
      logic [W-1:0] d;
      logic         en;
      a = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: d = $urandom();
        1: d = $urandom() & $urandom();
        2: d = '1;
        default: d = 32'(1) << $urandom_range(0, W - 1);
      endcase
      en = ($urandom_range(0, 7) != 0);
      bus_write(a, d, en);
      check_pads(en ? "R2 R3 R4 R5 R6 random" : "R10 random idle");
      check("R7 random overlap", pu_en & pd_en, '0);
      if (i % 8 == 0) bus_read("R8 R9 random read", 3'($urandom_range(0, 7)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule